// File: doc/BRIEF.md
# Clock Controller Register File

This block is the configuration store of a clock control unit. It answers a simple 32-bit bus whose 4 KB window is addressed by word. It holds nine registers: a mode register, two post-divider registers, two PLL control registers, three clock-gating registers and one power-mode register. All register contents drive output ports, so the frequency and gating logic beside the block can read them directly. Each writable register keeps only the bits its own mask allows. The mode register also holds one bit that is always set.

Any write that can change a derived clock frequency makes the block raise `recalc_pulse` for one cycle. These writes are the ones to the mode, post-divider and PLL registers. The block gives the same pulse once just after reset, so the neighbouring frequency logic starts from valid settings. Writes to the gating registers, to the power-mode register, to the constant location and to unmapped words change no frequency, so they give no pulse.

The request side is a valid/ready channel. The block never applies back-pressure, so `bus_req_ready` is held high and a request is taken in every cycle where `bus_req_valid` is high. A read returns its data exactly one cycle after it is taken. The response channel has no ready input, so the receiver must accept every response.

Top module: `ccr_regbank`

## Requirements
- R1: During and after reset, with no writes made, the registers hold: mode 0x074b0b7b, post-divider 0 0xff870b48, post-divider 1 0x49fcfe7f, main PLL 0x04001800 (bits [29:26]=1, [25:16]=0, [13:10]=6, [9:0]=0), secondary PLL 0x04043001 (bits [29:26]=1, [25:16]=4, [13:10]=0xc, [9:0]=1), each gating register 0xffffffff, power-mode 0x80209828.
- R2: `bus_req_ready` is always high. An accepted read raises `bus_rsp_valid` with its data in the following cycle, and `bus_rsp_valid` stays low in every other cycle.
- R3: A write to word 0 (mode) stores the write data ANDed with 0x3b6fdfff, with bit 26 forced to 1. Bit 26 of the mode register is therefore never 0.
- R4: A write to word 1 (post-divider 0) keeps only the bits set in 0xff9f3fff. A write to word 2 (post-divider 1) keeps all 32 bits.
- R5: A write to word 4 (main PLL) or word 6 (secondary PLL) keeps only the bits set in 0xbfff3fff.
- R6: Words 8, 9 and 10 are the gating registers 0, 1 and 2. They store all 32 written bits and appear in `cfg_gate` at bit offsets 0, 32 and 64.
- R7: A read of word 18 returns 0x00004040. A read of any other unmapped word returns zero. Writes to these words are ignored.
- R8: Word 23 (power-mode) can be read, and bus writes to it have no effect.
- R9: A write to word 0, 1, 2, 4 or 6 makes `recalc_pulse` high for exactly the one cycle after the write is accepted.
- R10: A write to a gating register, to word 18, to word 23 or to an unmapped word leaves `recalc_pulse` low.
- R11: `recalc_pulse` is low during reset. It is high for exactly one cycle, the first cycle after the first clock edge with reset released.
- R12: Byte address bits [11:2] select the word, and bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_valid | input | 1 | Request present |
| bus_req_ready | output | 1 | Request accepted (always high) |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | ADDR_W | Byte address |
| bus_req_wdata | input | 32 | Write data |
| bus_rsp_valid | output | 1 | Read data present |
| bus_rsp_data | output | 32 | Read data |
| recalc_pulse | output | 1 | One-cycle request to recompute frequencies |
| cfg_mode | output | 32 | Mode register |
| cfg_pdiv0 | output | 32 | Post-divider 0 |
| cfg_pdiv1 | output | 32 | Post-divider 1 |
| cfg_mpll | output | 32 | Main PLL control |
| cfg_spll | output | 32 | Secondary PLL control |
| cfg_gate | output | 96 | Three gating registers, register 0 in the low bits |
| cfg_pwr | output | 32 | Power-mode register |

## Verification
The mask checks use two kinds of write data. All-ones data shows the mask directly. A mixed pattern shows that data bits arrive in the right places and are not just forced. Writing all zeros to the mode register separates the forced bit 26 from a bit that is only passed through the mask. Writes to the gating registers, the constant word, the power-mode word and an unmapped word, each read back afterwards, separate stores that trigger a recompute from those that do not. They also show that read-only words keep their values. One read and one write use an address with the low two bits set, to show that byte offsets alias to the same word.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DW   = 32;
  localparam int NREG = 9;

  typedef logic [DW-1:0] word_t;

  // Register slot indices
  localparam int IX_MODE  = 0;
  localparam int IX_PDIV0 = 1;
  localparam int IX_PDIV1 = 2;
  localparam int IX_MPLL  = 3;
  localparam int IX_SPLL  = 4;
  localparam int IX_GATE0 = 5;
  localparam int IX_PWR   = 8;
  localparam int GATE_N   = 3;

  localparam int    CONST_WORD = 18;
  localparam word_t CONST_VAL  = 32'h0000_4040;

  function automatic int unsigned word_of(int i);
    case (i)
      IX_MODE:  return 0;
      IX_PDIV0: return 1;
      IX_PDIV1: return 2;
      IX_MPLL:  return 4;
      IX_SPLL:  return 6;
      5:        return 8;
      6:        return 9;
      7:        return 10;
      default:  return 23;
    endcase
  endfunction

  function automatic word_t wmask_of(int i);
    case (i)
      IX_MODE:          return 32'h3b6f_dfff;
      IX_PDIV0:         return 32'hff9f_3fff;
      IX_MPLL, IX_SPLL: return 32'hbfff_3fff;
      IX_PWR:           return 32'h0000_0000;
      default:          return 32'hffff_ffff;
    endcase
  endfunction

  function automatic word_t force_of(int i);
    return (i == IX_MODE) ? 32'h0400_0000 : 32'h0;
  endfunction

  // PLL field packing: pre-divider [29:26], denominator [25:16],
  // integer [13:10], numerator [9:0]
  function automatic word_t pll_word(int pd, int mfd, int mfi, int mfn);
    return (word_t'(pd & 'hf) << 26) | (word_t'(mfd & 'h3ff) << 16) |
           (word_t'(mfi & 'hf) << 10) | word_t'(mfn & 'h3ff);
  endfunction

  function automatic word_t reset_of(int i);
    case (i)
      IX_MODE:  return 32'h074b_0b7b;
      IX_PDIV0: return 32'hff87_0b48;
      IX_PDIV1: return 32'h49fc_fe7f;
      IX_MPLL:  return pll_word(1, 0, 6, 0);
      IX_SPLL:  return pll_word(1, 4, 'hc, 1);
      IX_PWR:   return 32'h8020_9828;
      default:  return 32'hffff_ffff;
    endcase
  endfunction

  function automatic bit writable_of(int i);
    return i != IX_PWR;
  endfunction

  function automatic logic [NREG-1:0] freq_set();
    logic [NREG-1:0] m;
    m = '0;
    for (int i = 0; i < NREG; i++)
      m[i] = (i <= IX_SPLL);
    return m;
  endfunction
endpackage

// File: rtl/ccr_addr_decode.sv
module ccr_addr_decode
  import ccr_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output logic [NREG-1:0]   hit,
  output logic              const_hit,
  output logic              freq_hit
);
  localparam logic [NREG-1:0] FREQ_SET = freq_set();

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = (word == WORD_W'(word_of(g)));
  end

  assign const_hit = (word == WORD_W'(CONST_WORD));
  assign freq_hit  = |(hit & FREQ_SET);
endmodule

// File: rtl/ccr_field_reg.sv
module ccr_field_reg
  import ccr_pkg::*;
#(
  parameter word_t RESET_VAL = '0,
  parameter word_t WMASK     = '1,
  parameter word_t FORCE_SET = '0,
  parameter bit    WRITABLE  = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);
  if (WRITABLE) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst)     q <= RESET_VAL;
      else if (we) q <= (wdata & WMASK) | FORCE_SET;
    end
  end else begin : g_ro
    logic unused_we;
    word_t unused_wd;
    assign unused_we = we;
    assign unused_wd = wdata;
    always_ff @(posedge clk) begin
      if (rst) q <= RESET_VAL;
    end
  end
endmodule

// File: rtl/ccr_read_mux.sv
module ccr_read_mux
  import ccr_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [NREG-1:0]         hit,
  input  logic                    const_hit,
  output word_t                   rdata
);
  always_comb begin
    rdata = const_hit ? CONST_VAL : '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rdata = rdata | regs[i];
  end
endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_req_valid,
  output logic                    bus_req_ready,
  input  logic                    bus_req_write,
  input  logic [ADDR_W-1:0]       bus_req_addr,
  input  logic [31:0]             bus_req_wdata,
  output logic                    bus_rsp_valid,
  output logic [31:0]             bus_rsp_data,
  output logic                    recalc_pulse,
  output logic [31:0]             cfg_mode,
  output logic [31:0]             cfg_pdiv0,
  output logic [31:0]             cfg_pdiv1,
  output logic [31:0]             cfg_mpll,
  output logic [31:0]             cfg_spll,
  output logic [GATE_N*DW-1:0]    cfg_gate,
  output logic [31:0]             cfg_pwr
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]       word;
  logic [NREG-1:0]         hit;
  logic                    const_hit;
  logic                    freq_hit;
  logic                    wr_fire;
  logic                    rd_fire;
  logic [NREG-1:0][DW-1:0] regs;
  word_t                   rdata;
  logic                    boot_pend;
  logic                    unused_lsb;

  assign bus_req_ready = 1'b1;
  assign word       = bus_req_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_req_addr[1:0];
  assign wr_fire    = bus_req_valid & bus_req_ready & bus_req_write;
  assign rd_fire    = bus_req_valid & bus_req_ready & ~bus_req_write;

  ccr_addr_decode #(.WORD_W(WORD_W)) dec_i (
    .word      (word),
    .hit       (hit),
    .const_hit (const_hit),
    .freq_hit  (freq_hit)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    ccr_field_reg #(
      .RESET_VAL (reset_of(g)),
      .WMASK     (wmask_of(g)),
      .FORCE_SET (force_of(g)),
      .WRITABLE  (writable_of(g))
    ) reg_i (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_fire & hit[g]),
      .wdata (bus_req_wdata),
      .q     (regs[g])
    );
  end

  ccr_read_mux rmux_i (
    .regs      (regs),
    .hit       (hit),
    .const_hit (const_hit),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rsp_valid <= 1'b0;
      bus_rsp_data  <= '0;
    end else begin
      bus_rsp_valid <= rd_fire;
      if (rd_fire) bus_rsp_data <= rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pend    <= 1'b1;
      recalc_pulse <= 1'b0;
    end else begin
      boot_pend    <= 1'b0;
      recalc_pulse <= boot_pend | (wr_fire & freq_hit);
    end
  end

  assign cfg_mode  = regs[IX_MODE];
  assign cfg_pdiv0 = regs[IX_PDIV0];
  assign cfg_pdiv1 = regs[IX_PDIV1];
  assign cfg_mpll  = regs[IX_MPLL];
  assign cfg_spll  = regs[IX_SPLL];
  assign cfg_pwr   = regs[IX_PWR];

  for (genvar k = 0; k < GATE_N; k++) begin : g_gate
    assign cfg_gate[k*DW +: DW] = regs[IX_GATE0 + k];
  end
endmodule

// File: rtl/ccr_regbank_chk.sv
module ccr_regbank_chk
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req_valid,
  input logic                 bus_req_ready,
  input logic                 bus_req_write,
  input logic [ADDR_W-1:0]    bus_req_addr,
  input logic [31:0]          bus_req_wdata,
  input logic                 bus_rsp_valid,
  input logic [31:0]          bus_rsp_data,
  input logic                 recalc_pulse,
  input logic [31:0]          cfg_mode,
  input logic [31:0]          cfg_pdiv0,
  input logic [31:0]          cfg_pdiv1,
  input logic [31:0]          cfg_mpll,
  input logic [31:0]          cfg_spll,
  input logic [GATE_N*DW-1:0] cfg_gate,
  input logic [31:0]          cfg_pwr
);
  logic [ADDR_W-3:0] cword;
  logic              rd_acc;
  logic              wr_acc;
  assign cword  = bus_req_addr[ADDR_W-1:2];
  assign rd_acc = bus_req_valid && bus_req_ready && !bus_req_write;
  assign wr_acc = bus_req_valid && bus_req_ready && bus_req_write;

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> bus_rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> !bus_rsp_valid);

  assert_mode_bit_forced_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> cfg_mode[26]);

  assert_pwr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg_pwr));

  assert_const_word_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && cword == 18) |=> (bus_rsp_data == 32'h0000_4040));

  assert_mode_write_recalc_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && cword == 0) |=> recalc_pulse);

  assert_gate_no_recalc_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && cword >= 8 && cword <= 10 && !$past(rst)) |=> !recalc_pulse);
endmodule

bind ccr_regbank ccr_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ccr_regbank_tb_top.sv
module ccr_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req_valid = 1'b0;
  logic        bus_req_ready;
  logic        bus_req_write = 1'b0;
  logic [11:0] bus_req_addr = '0;
  logic [31:0] bus_req_wdata = '0;
  logic        bus_rsp_valid;
  logic [31:0] bus_rsp_data;
  logic        recalc_pulse;
  logic [31:0] cfg_mode, cfg_pdiv0, cfg_pdiv1, cfg_mpll, cfg_spll, cfg_pwr;
  logic [95:0] cfg_gate;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ccr_regbank dut_i (
    .clk(clk), .rst(rst),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .recalc_pulse(recalc_pulse),
    .cfg_mode(cfg_mode), .cfg_pdiv0(cfg_pdiv0), .cfg_pdiv1(cfg_pdiv1),
    .cfg_mpll(cfg_mpll), .cfg_spll(cfg_spll), .cfg_gate(cfg_gate),
    .cfg_pwr(cfg_pwr)
  );

  task automatic check(input logic [95:0] act, input logic [95:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare each read response against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(96'(bus_rsp_data), 96'hx, "R2 unexpected response");
      end else begin
        check(96'(bus_rsp_data), 96'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_write = 1'b0; bus_req_addr = a;
    @(negedge clk);
    bus_req_valid = 1'b0;
    @(negedge clk);
    check(96'(bus_rsp_valid), 96'd0, {tag, " rsp_valid single cycle"});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          input bit exp_pulse, input string tag);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_write = 1'b1; bus_req_addr = a; bus_req_wdata = d;
    @(negedge clk);
    bus_req_valid = 1'b0; bus_req_write = 1'b0;
    check(96'(recalc_pulse), 96'(exp_pulse), {tag, " pulse"});
    @(negedge clk);
    check(96'(recalc_pulse), 96'd0, {tag, " pulse ends"});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    check(96'(recalc_pulse), 96'd0, "R11 no pulse in reset");
    check(96'(bus_rsp_valid), 96'd0, "R2 no response in reset");
    check(96'(bus_req_ready), 96'd1, "R2 ready high");
    rst = 1'b0;
    @(negedge clk);
    check(96'(recalc_pulse), 96'd1, "R11 boot pulse");
    @(negedge clk);
    check(96'(recalc_pulse), 96'd0, "R11 boot pulse single");

    // R1: reset contents
    check(96'(cfg_mode),  96'h074b0b7b, "R1 mode");
    check(96'(cfg_pdiv0), 96'hff870b48, "R1 pdiv0");
    check(96'(cfg_pdiv1), 96'h49fcfe7f, "R1 pdiv1");
    check(96'(cfg_mpll),  96'h04001800, "R1 mpll");
    check(96'(cfg_spll),  96'h04043001, "R1 spll");
    check(cfg_gate, {96{1'b1}}, "R1 gates");
    check(96'(cfg_pwr), 96'h80209828, "R1 pwr");
    do_read(12'h000, 32'h074b0b7b, "R1 read mode");
    do_read(12'h010, 32'h04001800, "R1 read mpll");
    do_read(12'h018, 32'h04043001, "R1 read spll");
    do_read(12'h028, 32'hffffffff, "R1 read gate2");
    do_read(12'h05c, 32'h80209828, "R1 read pwr");

    // R3: mode mask and forced bit
    do_write(12'h000, 32'hffffffff, 1'b1, "R9 mode write");
    do_read(12'h000, 32'h3f6fdfff, "R3 mode all ones");
    do_write(12'h000, 32'h00000000, 1'b1, "R9 mode write zero");
    do_read(12'h000, 32'h04000000, "R3 mode forced bit");
    check(96'(cfg_mode), 96'h04000000, "R3 mode port");

    // R4
    do_write(12'h004, 32'hffffffff, 1'b1, "R9 pdiv0 write");
    do_read(12'h004, 32'hff9f3fff, "R4 pdiv0 mask");
    do_write(12'h008, 32'hdeadbeef, 1'b1, "R9 pdiv1 write");
    do_read(12'h008, 32'hdeadbeef, "R4 pdiv1 full");

    // R5
    do_write(12'h010, 32'hffffffff, 1'b1, "R9 mpll write");
    do_read(12'h010, 32'hbfff3fff, "R5 mpll mask");
    do_write(12'h018, 32'h12345678, 1'b1, "R9 spll write");
    do_read(12'h018, 32'h12341678, "R5 spll mask");
    check(96'(cfg_spll), 96'h12341678, "R5 spll port");

    // R6 / R10: gating registers
    do_write(12'h020, 32'h0000ffff, 1'b0, "R10 gate0 write");
    do_write(12'h024, 32'ha5a5a5a5, 1'b0, "R10 gate1 write");
    do_write(12'h028, 32'h3c3c0001, 1'b0, "R10 gate2 write");
    do_read(12'h024, 32'ha5a5a5a5, "R6 gate1 readback");
    check(cfg_gate, {32'h3c3c0001, 32'ha5a5a5a5, 32'h0000ffff}, "R6 gate port order");

    // R8: power register frozen
    do_write(12'h05c, 32'h00000000, 1'b0, "R10 pwr write");
    do_read(12'h05c, 32'h80209828, "R8 pwr unchanged");
    check(96'(cfg_pwr), 96'h80209828, "R8 pwr port");

    // R7: constant and unmapped words
    do_write(12'h048, 32'hffffffff, 1'b0, "R10 const write");
    do_read(12'h048, 32'h00004040, "R7 const word");
    do_read(12'h00c, 32'h00000000, "R7 unmapped word 3");
    do_write(12'h014, 32'hffffffff, 1'b0, "R10 unmapped write");
    do_read(12'h014, 32'h00000000, "R7 unmapped word 5");
    do_read(12'hffc, 32'h00000000, "R7 unmapped top word");
    check(96'(cfg_pdiv1), 96'hdeadbeef, "R7 unmapped write no side effect");

    // R12: byte offset bits ignored
    do_write(12'h009, 32'h11111111, 1'b1, "R12 offset write");
    do_read(12'h00b, 32'h11111111, "R12 offset read");

    repeat (2) @(negedge clk);
    check(96'(exp_q.size()), 96'd0, "R2 all responses seen");
    finished = 1;
    summary();
    $finish;
  end
endmodule